// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the configuration front end of a legacy I/O controller. It sits on a byte-wide I/O bus with an address, a read strobe, a write strobe and write/read data. It answers at two addresses: an index port at a strap-selected base and a data port one address above it. The interface starts locked. Software opens it by writing a fixed key byte to the index port on two successive index writes, and closes it again with a separate close key.

While the interface is open, writing the index port picks a configuration register, and the data port reads or writes the register picked. A device-select register chooses which per-device bank of registers shows up in the upper index range. Below that range sit read-only identification bytes: a 16-bit device code, a revision and a 16-bit maker code. The bank that belongs to the GPIO logical device is also driven out as a flat vector, so the GPIO function next to this block can use its settings.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the interface is locked, the device select is 0, every bank register is 0x00 (so `gpio_cfg` is all zero), and `io_rdata` is 0xFF.
- R2: The interface opens only after two index-port writes of 0x87 in a row. Any other byte written to the index port while it is locked or half-unlocked returns the sequence to its start.
- R3: An index-port write of 0xAA while open locks the interface. The current index is kept for the next session.
- R4: While locked, data-port writes change no register, and reads of either port return 0xFF.
- R5: While open, an index-port write of any byte other than 0xAA loads the index, and an index-port read returns that index.
- R6: Identification reads through the data port: index 0x20 gives the device code high byte, 0x21 its low byte, 0x22 the revision, 0x23 gives 0x19 and 0x24 gives 0x34 (maker code 0x1934). With the default parameters the device code is 0x5A21 and the revision is 0x03.
- R7: Data-port writes to indices 0x20 to 0x24 are discarded.
- R8: Index 0x07 holds the device select and reads back the byte written. Indices 0x30 to 0x37 reach the bank of the selected device, and each device number has its own storage.
- R9: `gpio_cfg[8*r+7:8*r]` equals bank register 0x30+r of device 6 and changes on the clock edge that samples the data write.
- R10: Only addresses BASE (default 0x2E) and BASE+1 are decoded. Accesses at any other address, including the alternative base 0x4E, change nothing and read 0xFF.
- R11: `io_rdata` is registered. It takes the read value on the clock edge that samples `io_rd` and holds it until the next read.
- R12: Unimplemented indices, and bank indices while the device select is 8 or more, read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| gpio_cfg | output | 64 | Bank contents of the GPIO logical device |

## Verification
The bound checker watches the lock state on every cycle. It checks that the interface never opens except on a 0x87 index write, that 0xAA always locks it, that reads while locked return 0xFF, that the maker code high byte is constant, and that `gpio_cfg` never moves without a data-port write. The broken key sequence, the index kept across a lock cycle, the separate storage for each device, writes that are discarded, and the alternative base being ignored only show up as read-back values in the bench's ordered scenarios.

// File: rtl/keyed_cfg_pkg.sv
// Shared constants and types for the keyed configuration port.
// Assumes an 8-bit index space and 8-bit data.
package keyed_cfg_pkg;
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    localparam logic [7:0]  KEY_OPEN      = 8'h87;
    localparam logic [7:0]  KEY_CLOSE     = 8'hAA;
    localparam logic [7:0]  IDX_DEV_SEL   = 8'h07;
    localparam logic [7:0]  IDX_CODE_HI   = 8'h20;
    localparam logic [7:0]  IDX_CODE_LO   = 8'h21;
    localparam logic [7:0]  IDX_REVISION  = 8'h22;
    localparam logic [7:0]  IDX_MAKER_HI  = 8'h23;
    localparam logic [7:0]  IDX_MAKER_LO  = 8'h24;
    localparam logic [7:0]  IDX_BANK_BASE = 8'h30;
    localparam logic [15:0] MAKER_CODE    = 16'h1934;
    localparam logic [7:0]  IDLE_BYTE     = 8'hFF;
endpackage

// File: rtl/keyed_cfg_lock.sv
// Key sequencer: follows index-port writes and opens the interface after two
// successive open keys. A close key locks it again.
// Assumes idx_wr is a single-cycle strobe that is already address-qualified.
module keyed_cfg_lock
    import keyed_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       is_open
);
    key_state_e state_q, state_d;

    // Next-state logic for the unlock sequence
    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                KS_LOCKED: state_d = (wdata == KEY_OPEN)  ? KS_HALF   : KS_LOCKED;
                KS_HALF:   state_d = (wdata == KEY_OPEN)  ? KS_OPEN   : KS_LOCKED;
                KS_OPEN:   state_d = (wdata == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
                default:   state_d = KS_LOCKED;
            endcase
        end
    end

    // State register, locked out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    assign is_open = (state_q == KS_OPEN);
endmodule

// File: rtl/keyed_cfg_regs.sv
// Configuration register file: index register, device select, fixed
// identification bytes and a bank of registers for each logical device.
// Assumes NUM_DEV >= 2, BANK_REGS >= 2 and the banks fit below index 0x100.
module keyed_cfg_regs
    import keyed_cfg_pkg::*;
#(
    parameter int          NUM_DEV   = 8,
    parameter int          BANK_REGS = 8,
    parameter int          GPIO_LDN  = 6,
    parameter logic [15:0] DEV_CODE  = 16'h5A21,
    parameter logic [7:0]  REVISION  = 8'h03
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   idx_load,
    input  logic                   dat_wr,
    input  logic [7:0]             wdata,
    output logic [7:0]             cur_idx,
    output logic [7:0]             rd_val,
    output logic [BANK_REGS*8-1:0] gpio_cfg
);
    localparam int         OFF_W    = $clog2(BANK_REGS);
    localparam int         DEV_W    = $clog2(NUM_DEV);
    localparam logic [7:0] NUM_DEV_B = 8'(NUM_DEV);
    localparam logic [7:0] BANK_END  = IDX_BANK_BASE + 8'(BANK_REGS);

    logic [7:0]       idx_q;
    logic [7:0]       sel_q;
    logic             bank_hit;
    logic             dev_hit;
    logic [7:0]       idx_rel;
    logic [OFF_W-1:0] bank_off;
    logic [7:0]       dev_rd [NUM_DEV];

    assign bank_hit = (idx_q >= IDX_BANK_BASE) && (idx_q < BANK_END);
    assign dev_hit  = (sel_q < NUM_DEV_B);
    assign idx_rel  = idx_q - IDX_BANK_BASE;
    assign bank_off = idx_rel[OFF_W-1:0];
    assign cur_idx  = idx_q;

    // Index register, loaded by index-port writes while open
    always_ff @(posedge clk) begin
        if (!rst_n)        idx_q <= 8'h00;
        else if (idx_load) idx_q <= wdata;
    end

    // Device-select register
    always_ff @(posedge clk) begin
        if (!rst_n)                              sel_q <= 8'h00;
        else if (dat_wr && idx_q == IDX_DEV_SEL) sel_q <= wdata;
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic [7:0] regs_q [BANK_REGS];
        logic       wr_sel;
        assign wr_sel = dat_wr && bank_hit && (sel_q == 8'(d));

        // Bank storage for logical device d
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < BANK_REGS; r++) regs_q[r] <= 8'h00;
            end else if (wr_sel) begin
                regs_q[bank_off] <= wdata;
            end
        end

        assign dev_rd[d] = regs_q[bank_off];

        if (d == GPIO_LDN) begin : g_gpio
            for (genvar r = 0; r < BANK_REGS; r++) begin : g_out
                assign gpio_cfg[r*8 +: 8] = regs_q[r];
            end
        end
    end

    // Read multiplexer over the whole index space
    always_comb begin
        rd_val = 8'h00;
        if (bank_hit) begin
            if (dev_hit) rd_val = dev_rd[sel_q[DEV_W-1:0]];
        end else begin
            unique case (idx_q)
                IDX_DEV_SEL:  rd_val = sel_q;
                IDX_CODE_HI:  rd_val = DEV_CODE[15:8];
                IDX_CODE_LO:  rd_val = DEV_CODE[7:0];
                IDX_REVISION: rd_val = REVISION;
                IDX_MAKER_HI: rd_val = MAKER_CODE[15:8];
                IDX_MAKER_LO: rd_val = MAKER_CODE[7:0];
                default:      rd_val = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/keyed_cfg_port.sv
// Top level: decodes the index/data window on the I/O bus, gates data access
// with the key sequencer and registers the read data.
// Assumes io_rd and io_wr are single-cycle strobes and are never both high.
module keyed_cfg_port
    import keyed_cfg_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE      = 16'h002E,
    parameter int          NUM_DEV   = 8,
    parameter int          BANK_REGS = 8,
    parameter int          GPIO_LDN  = 6,
    parameter logic [15:0] DEV_CODE  = 16'h5A21,
    parameter logic [7:0]  REVISION  = 8'h03
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      io_addr,
    input  logic                   io_rd,
    input  logic                   io_wr,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    output logic [BANK_REGS*8-1:0] gpio_cfg
);
    localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE) + ADDR_W'(1);

    logic       idx_hit, dat_hit;
    logic       is_open;
    logic [7:0] cur_idx, rd_val;

    assign idx_hit = (io_addr == IDX_ADDR);
    assign dat_hit = (io_addr == DAT_ADDR);

    keyed_cfg_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (io_wr && idx_hit),
        .wdata   (io_wdata),
        .is_open (is_open)
    );

    keyed_cfg_regs #(
        .NUM_DEV   (NUM_DEV),
        .BANK_REGS (BANK_REGS),
        .GPIO_LDN  (GPIO_LDN),
        .DEV_CODE  (DEV_CODE),
        .REVISION  (REVISION)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_load (io_wr && idx_hit && is_open && (io_wdata != KEY_CLOSE)),
        .dat_wr   (io_wr && dat_hit && is_open),
        .wdata    (io_wdata),
        .cur_idx  (cur_idx),
        .rd_val   (rd_val),
        .gpio_cfg (gpio_cfg)
    );

    // Registered read data, 0xFF when locked or outside the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_rdata <= IDLE_BYTE;
        end else if (io_rd) begin
            if (idx_hit && is_open)      io_rdata <= cur_idx;
            else if (dat_hit && is_open) io_rdata <= rd_val;
            else                         io_rdata <= IDLE_BYTE;
        end
    end
endmodule

// File: rtl/keyed_cfg_checker.sv
// Protocol checker for keyed_cfg_port, attached by bind. It observes the
// ports plus the open flag and the current index.
module keyed_cfg_checker #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE      = 16'h002E,
    parameter int          BANK_REGS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      io_addr,
    input logic                   io_rd,
    input logic                   io_wr,
    input logic [7:0]             io_wdata,
    input logic [7:0]             io_rdata,
    input logic [BANK_REGS*8-1:0] gpio_cfg,
    input logic                   is_open,
    input logic [7:0]             cur_idx
);
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE) + ADDR_W'(1);

    // R2: opening is always caused by an open-key index write
    a_r2_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> $past(io_wr && io_addr == IDX_A && io_wdata == 8'h87));

    // R3: the close key always locks
    a_r3_close_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && io_wr && io_addr == IDX_A && io_wdata == 8'hAA) |=> !is_open);

    // R4: reads while locked return the idle byte
    a_r4_locked_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_open && io_rd) |=> (io_rdata == 8'hFF));

    // R6: maker code high byte is fixed
    a_r6_maker_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && io_rd && io_addr == DAT_A && cur_idx == 8'h23) |=> (io_rdata == 8'h19));

    // R9: GPIO bank output moves only after a data-port write
    a_r9_gpio_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == DAT_A) |=> $stable(gpio_cfg));

    // R11: read data holds when no read is strobed
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));
endmodule

bind keyed_cfg_port keyed_cfg_checker #(
    .ADDR_W    (ADDR_W),
    .BASE      (BASE),
    .BANK_REGS (BANK_REGS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .gpio_cfg (gpio_cfg),
    .is_open  (is_open),
    .cur_idx  (cur_idx)
);

// File: tb/keyed_cfg_port_tb_top.sv
// Scoreboard bench: the read driver queues expected bytes, and a monitor
// compares them with io_rdata one cycle after each read strobe.
module keyed_cfg_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] IDX = 16'h002E;
    localparam logic [15:0] DAT = 16'h002F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [63:0] gpio_cfg;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_cfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .gpio_cfg(gpio_cfg)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
        wr(IDX, i);
        wr(DAT, d);
    endtask

    task automatic reg_rd(input logic [7:0] i, input logic [7:0] exp, input string tag);
        wr(IDX, i);
        rd(DAT, exp, tag);
    endtask

    // Monitor: note read strobes at the edge, compare at the following negedge
    always @(posedge clk) rd_seen <= io_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected read", 64'(io_rdata), 64'hx);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, 64'(io_rdata), 64'(e));
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", 64'(io_rdata), 64'hFF);
        check("R1 gpio_cfg after reset", gpio_cfg, 64'h0);
        rd(DAT, 8'hFF, "R4 locked data read");
        // R2 broken sequence
        wr(IDX, 8'h87); wr(IDX, 8'h55); wr(IDX, 8'h87);
        rd(DAT, 8'hFF, "R2 broken key stays locked");
        wr(IDX, 8'h87);
        rd(IDX, 8'h00, "R5 index after unlock");
        rd(DAT, 8'h00, "R12 unimplemented index 0");
        // R6 / R7 identification
        reg_rd(8'h20, 8'h5A, "R6 code hi");
        reg_rd(8'h21, 8'h21, "R6 code lo");
        reg_rd(8'h22, 8'h03, "R6 revision");
        reg_rd(8'h23, 8'h19, "R6 maker hi");
        reg_rd(8'h24, 8'h34, "R6 maker lo");
        reg_wr(8'h20, 8'hFF);
        rd(DAT, 8'h5A, "R7 id write discarded");
        rd(IDX, 8'h20, "R5 index readback");
        // R8 paging
        reg_wr(8'h07, 8'h02);
        rd(DAT, 8'h02, "R8 select readback");
        reg_wr(8'h30, 8'hA1);
        reg_wr(8'h07, 8'h03);
        reg_rd(8'h30, 8'h00, "R8 device 3 separate");
        reg_wr(8'h07, 8'h02);
        reg_rd(8'h30, 8'hA1, "R8 device 2 kept");
        check("R9 gpio untouched by device 2", gpio_cfg, 64'h0);
        // R9 GPIO bank output
        reg_wr(8'h07, 8'h06);
        reg_wr(8'h31, 8'hC3);
        check("R9 gpio byte 1", gpio_cfg, 64'h0000_0000_0000_C300);
        reg_wr(8'h37, 8'h5E);
        check("R9 gpio byte 7", gpio_cfg, 64'h5E00_0000_0000_C300);
        // R12 select out of range
        reg_wr(8'h07, 8'h09);
        reg_wr(8'h30, 8'h11);
        rd(DAT, 8'h00, "R12 select 9 reads zero");
        reg_wr(8'h07, 8'h06);
        reg_rd(8'h30, 8'h00, "R12 write under select 9 dropped");
        // R10 other window ignored
        wr(16'h004E, 8'hAA);
        wr(16'h004F, 8'h00);
        rd(16'h004F, 8'hFF, "R10 alternate window reads idle");
        wr(IDX, 8'h31);
        rd(DAT, 8'hC3, "R10 still open, bank intact");
        // R3 relock, R4 ignored writes
        wr(IDX, 8'hAA);
        rd(DAT, 8'hFF, "R3 locked after close key");
        rd(IDX, 8'hFF, "R4 locked index read");
        wr(DAT, 8'h00);
        check("R4 locked write ignored", gpio_cfg, 64'h5E00_0000_0000_C300);
        wr(IDX, 8'h87); wr(IDX, 8'h87);
        rd(IDX, 8'h31, "R3 index kept across lock");
        rd(DAT, 8'hC3, "R4 register unchanged");
        repeat (3) @(negedge clk);
        check("R11 all reads compared", 64'(exp_q.size()), 64'h0);
        finish_run();
    end
endmodule